// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a blocking data cache that sits between a processor's load/store port and a slower memory. Each request carries one word and a 44-bit physical byte address. The cache holds 64-byte blocks in a two-way set-associative array. A request that hits completes without touching memory. A request that misses fetches the whole block from memory as a burst of words and then completes. Stores are written back: they update only the cached copy and mark that block modified. Memory sees the new data only when the block is later evicted.

A modified block chosen for eviction is copied, together with its block address, into a one-block side buffer. That buffer streams the block to memory on its own write channel. Meanwhile the refill of the missing block proceeds on the read channel. A later load to the parked block is answered from the buffer. A store to the parked block waits until the buffer has emptied.

The set count, block size, word width and address width are parameters. The defaults give 512 sets of two ways, which is 64 KiB. A test configuration can shrink the index to a few bits.

Top module: `dc_wb2way`

## Requirements
- R1: The byte address splits, from the top, into tag, set index and block offset. With the defaults, the tag is bits 43..15, the index is bits 14..6 and the word-in-block is bits 5..2. Two addresses that differ only in their word bits share one block.
- R2: After reset, `cpu_ready` is 1 and `cpu_resp`, `rf_req` and `wb_valid` are 0. Every way is invalid, so the first access to any block misses.
- R3: A load that hits gets `cpu_resp` for exactly one cycle on the second rising edge after the edge that accepted it. It returns the addressed word and raises no `rf_req`.
- R4: Every load returns the most recent value stored to its address, or the memory contents if no store was made, across any sequence of evictions.
- R5: A store that hits updates only the cache. No refill is requested and no word is written to memory, and a later load returns the stored word.
- R6: On a miss, `rf_req` is raised with `rf_addr` set to the block base (offset bits zero). It is held stable until `rf_gnt`. The block then arrives as 2^OFFS_W/(WORD_W/8) words in ascending word order on `rf_valid`.
- R7: A store miss allocates: the block is refilled, then the store is applied and the block becomes modified. When that block is later evicted, its write-back carries the stored word.
- R8: On a miss, an invalid way of the set is filled before any valid way is replaced. With both ways valid, the way that was not used by the most recent hit or fill in that set is replaced.
- R9: Evicting an unmodified block writes nothing to memory. Evicting a modified block writes every word of it, at the victim's own tag and index. `wb_addr` and `wb_data` are held while `wb_valid` is high and `wb_ready` is low.
- R10: A refill may be requested while the parked block is still waiting to be written back.
- R11: A miss whose victim is modified while the buffer is still occupied raises no `rf_req` until the buffer has emptied.
- R12: A load whose block sits in the victim buffer is answered from the buffer, with no refill. A store to that block gets no response and requests no refill until the buffer has emptied.
- R13: One request is handled at a time. `cpu_ready` is low from the cycle after acceptance until the response, and `rf_req` is never raised while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request valid; taken on a rising edge where `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_resp` |
| rf_req | output | 1 | Block refill request |
| rf_addr | output | ADDR_W | Block base address of the refill |
| rf_gnt | input | 1 | Memory has taken the refill request |
| rf_valid | input | 1 | One refill word present |
| rf_data | input | WORD_W | Refill word, lowest word first |
| wb_valid | output | 1 | One write-back word present |
| wb_addr | output | ADDR_W | Byte address of the write-back word |
| wb_data | output | WORD_W | Write-back word |
| wb_ready | input | 1 | Memory takes the write-back word this cycle |

## Verification
The hardest state to reach is one where the victim buffer is still occupied while the cache needs it again. That happens on a second modified eviction, on a load to the parked block, or on a store to the parked block. With memory accepting write-back words at once, the buffer empties within a few cycles, so none of these cases would occur. The bench therefore holds `wb_ready` low. Under that hold it fills one set with two modified blocks and forces a third block into the set, so a modified victim is parked. It then issues the conflicting access from a parallel thread. It confirms that no refill or response appears, releases the write channel, and checks the data that finally returns.

// File: rtl/dc_pkg.sv
package dc_pkg;
   localparam int WAYS = 2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_REQ,
      ST_FILL
   } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int TAG_W = 29,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] tag,
   output logic             hit,
   output logic             hit_way,
   output logic             victim_way,
   output logic             victim_dirty,
   output logic [TAG_W-1:0] victim_tag,
   input  logic             use_en,
   input  logic             use_way,
   input  logic             mark_en,
   input  logic             mark_way,
   input  logic             fill_en,
   input  logic             fill_way,
   input  logic [TAG_W-1:0] fill_tag
);
   localparam int SETS = 1 << IDX_W;

   logic [dc_pkg::WAYS-1:0] way_vld;
   logic [dc_pkg::WAYS-1:0] way_mod;
   logic [dc_pkg::WAYS-1:0] way_hit;
   logic [TAG_W-1:0]        way_tag [dc_pkg::WAYS];
   logic [SETS-1:0]         evict_q;

   generate
      for (genvar w = 0; w < dc_pkg::WAYS; w++) begin : g_way
         logic [TAG_W-1:0] tags_q [SETS];
         logic [SETS-1:0]  vld_q;
         logic [SETS-1:0]  mod_q;

         always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w))
               tags_q[idx] <= fill_tag;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
               mod_q <= '0;
            end else if (fill_en && fill_way == 1'(w)) begin
               vld_q[idx] <= 1'b1;
               mod_q[idx] <= 1'b0;
            end else if (mark_en && mark_way == 1'(w)) begin
               mod_q[idx] <= 1'b1;
            end
         end

         assign way_vld[w] = vld_q[idx];
         assign way_mod[w] = mod_q[idx];
         assign way_tag[w] = tags_q[idx];
         assign way_hit[w] = vld_q[idx] && (tags_q[idx] == tag);
      end
   endgenerate

   // evict_q names the way to replace next in each set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         evict_q <= '0;
      else if (fill_en)
         evict_q[idx] <= ~fill_way;
      else if (use_en)
         evict_q[idx] <= ~use_way;
   end

   assign hit          = |way_hit;
   assign hit_way      = way_hit[1];
   assign victim_way   = !way_vld[0] ? 1'b0 :
                         !way_vld[1] ? 1'b1 : evict_q[idx];
   assign victim_dirty = way_vld[victim_way] && way_mod[victim_way];
   assign victim_tag   = way_tag[victim_way];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int IDX_W  = 9,
   parameter int WORDS  = 16,
   parameter int WORD_W = 32
) (
   input  logic                     clk,
   input  logic [IDX_W-1:0]         idx,
   input  logic                     rd_way,
   input  logic [$clog2(WORDS)-1:0] rd_word,
   output logic [WORDS*WORD_W-1:0]  rd_blk,
   output logic [WORD_W-1:0]        rd_data,
   input  logic                     wr_en,
   input  logic                     wr_way,
   input  logic [$clog2(WORDS)-1:0] wr_word,
   input  logic [WORD_W-1:0]        wr_data
);
   localparam int SETS  = 1 << IDX_W;
   localparam int BLK_W = WORDS * WORD_W;

   logic [BLK_W-1:0] way_blk [dc_pkg::WAYS];

   generate
      for (genvar w = 0; w < dc_pkg::WAYS; w++) begin : g_way
         logic [BLK_W-1:0] blk_q [SETS];

         always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
               blk_q[idx][int'(wr_word)*WORD_W +: WORD_W] <= wr_data;
         end

         assign way_blk[w] = blk_q[idx];
      end
   endgenerate

   assign rd_blk  = way_blk[rd_way];
   assign rd_data = rd_blk[int'(rd_word)*WORD_W +: WORD_W];
endmodule

// File: rtl/dc_victim_buf.sv
module dc_victim_buf #(
   parameter int BADDR_W = 38,
   parameter int WORDS   = 16,
   parameter int WORD_W  = 32,
   parameter int BSEL_W  = 2
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     load_en,
   input  logic [BADDR_W-1:0]                       load_baddr,
   input  logic [WORDS*WORD_W-1:0]                  load_blk,
   input  logic [BADDR_W-1:0]                       chk_baddr,
   input  logic [$clog2(WORDS)-1:0]                 chk_word,
   output logic                                     busy,
   output logic                                     match,
   output logic [WORD_W-1:0]                        match_data,
   output logic                                     wb_valid,
   output logic [BADDR_W+$clog2(WORDS)+BSEL_W-1:0]  wb_addr,
   output logic [WORD_W-1:0]                        wb_data,
   input  logic                                     wb_ready
);
   localparam int WIDX_W = $clog2(WORDS);

   logic                    full_q;
   logic [WIDX_W-1:0]       cnt_q;
   logic [BADDR_W-1:0]      baddr_q;
   logic [WORDS*WORD_W-1:0] blk_q;

   always_ff @(posedge clk) begin
      if (load_en && !full_q) begin
         baddr_q <= load_baddr;
         blk_q   <= load_blk;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!full_q) begin
         full_q <= load_en;
         cnt_q  <= '0;
      end else if (wb_ready) begin
         if (cnt_q == WIDX_W'(WORDS - 1)) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign busy       = full_q;
   assign match      = full_q && (baddr_q == chk_baddr);
   assign match_data = blk_q[int'(chk_word)*WORD_W +: WORD_W];
   assign wb_valid   = full_q;
   assign wb_addr    = {baddr_q, cnt_q, {BSEL_W{1'b0}}};
   assign wb_data    = blk_q[int'(cnt_q)*WORD_W +: WORD_W];
endmodule

// File: rtl/dc_wb2way.sv
module dc_wb2way #(
   parameter int ADDR_W = 44,
   parameter int IDX_W  = 9,
   parameter int OFFS_W = 6,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_resp,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              rf_req,
   output logic [ADDR_W-1:0] rf_addr,
   input  logic              rf_gnt,
   input  logic              rf_valid,
   input  logic [WORD_W-1:0] rf_data,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [WORD_W-1:0] wb_data,
   input  logic              wb_ready
);
   import dc_pkg::*;

   localparam int BSEL_W  = $clog2(WORD_W / 8);
   localparam int WIDX_W  = OFFS_W - BSEL_W;
   localparam int WORDS   = 1 << WIDX_W;
   localparam int TAG_W   = ADDR_W - IDX_W - OFFS_W;
   localparam int BADDR_W = ADDR_W - OFFS_W;
   localparam int AQ_W    = ADDR_W - BSEL_W;
   localparam int BLK_W   = WORDS * WORD_W;

   generate
      if (WORD_W % 8 != 0 || (1 << BSEL_W) * 8 != WORD_W) begin : g_bad_word
         $error("WORD_W must be a power-of-two number of bytes");
      end
      if (WIDX_W < 1) begin : g_bad_offs
         $error("a block must hold at least two words");
      end
      if (IDX_W < 1 || TAG_W < 1) begin : g_bad_split
         $error("address too narrow for index and offset");
      end
   endgenerate

   dc_state_e         state_q;
   logic [AQ_W-1:0]   addr_q;
   logic              we_q;
   logic [WORD_W-1:0] wdata_q;
   logic              vway_q;
   logic [WIDX_W-1:0] fcnt_q;
   logic              resp_q;
   logic [WORD_W-1:0] rdata_q;

   logic [TAG_W-1:0]   req_tag;
   logic [IDX_W-1:0]   req_idx;
   logic [WIDX_W-1:0]  req_word;
   logic [BADDR_W-1:0] req_baddr;

   logic               hit, hit_way, victim_way, victim_dirty;
   logic [TAG_W-1:0]   victim_tag;
   logic [BLK_W-1:0]   rd_blk;
   logic [WORD_W-1:0]  rd_data;
   logic               vb_busy, vb_match;
   logic [WORD_W-1:0]  vb_word;

   logic in_lookup, in_fill, serve, go_fill, park, fill_last;
   logic use_en, use_way, wr_en, wr_way;
   logic [WIDX_W-1:0] wr_word;
   logic [WORD_W-1:0] wr_data;

   logic unused_lsb;
   assign unused_lsb = ^cpu_addr[BSEL_W-1:0];

   assign req_tag   = addr_q[AQ_W-1 -: TAG_W];
   assign req_idx   = addr_q[WIDX_W +: IDX_W];
   assign req_word  = addr_q[WIDX_W-1:0];
   assign req_baddr = addr_q[AQ_W-1:WIDX_W];

   assign in_lookup = (state_q == ST_LOOKUP);
   assign in_fill   = (state_q == ST_FILL);
   assign fill_last = in_fill && rf_valid && (fcnt_q == WIDX_W'(WORDS - 1));

   // decision taken after the tag compare of the latched request
   assign serve   = in_lookup && (hit || (vb_match && !we_q));
   assign go_fill = in_lookup && !hit && !vb_match && (!victim_dirty || !vb_busy);
   assign park    = go_fill && victim_dirty;

   assign use_en  = in_lookup && hit;
   assign use_way = hit_way;

   always_comb begin
      wr_en   = 1'b0;
      wr_way  = hit_way;
      wr_word = req_word;
      wr_data = wdata_q;
      if (in_lookup && hit && we_q) begin
         wr_en = 1'b1;
      end else if (in_fill && rf_valid) begin
         wr_en   = 1'b1;
         wr_way  = vway_q;
         wr_word = fcnt_q;
         wr_data = rf_data;
      end
   end

   dc_tag_store #(
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
   ) u_tags (
      .clk          (clk),
      .rst_n        (rst_n),
      .idx          (req_idx),
      .tag          (req_tag),
      .hit          (hit),
      .hit_way      (hit_way),
      .victim_way   (victim_way),
      .victim_dirty (victim_dirty),
      .victim_tag   (victim_tag),
      .use_en       (use_en),
      .use_way      (use_way),
      .mark_en      (in_lookup && hit && we_q),
      .mark_way     (hit_way),
      .fill_en      (fill_last),
      .fill_way     (vway_q),
      .fill_tag     (req_tag)
   );

   dc_data_store #(
      .IDX_W  (IDX_W),
      .WORDS  (WORDS),
      .WORD_W (WORD_W)
   ) u_data (
      .clk     (clk),
      .idx     (req_idx),
      .rd_way  (hit ? hit_way : victim_way),
      .rd_word (req_word),
      .rd_blk  (rd_blk),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_way  (wr_way),
      .wr_word (wr_word),
      .wr_data (wr_data)
   );

   dc_victim_buf #(
      .BADDR_W (BADDR_W),
      .WORDS   (WORDS),
      .WORD_W  (WORD_W),
      .BSEL_W  (BSEL_W)
   ) u_vbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (park),
      .load_baddr ({victim_tag, req_idx}),
      .load_blk   (rd_blk),
      .chk_baddr  (req_baddr),
      .chk_word   (req_word),
      .busy       (vb_busy),
      .match      (vb_match),
      .match_data (vb_word),
      .wb_valid   (wb_valid),
      .wb_addr    (wb_addr),
      .wb_data    (wb_data),
      .wb_ready   (wb_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         vway_q  <= 1'b0;
         fcnt_q  <= '0;
         resp_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         resp_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  addr_q  <= cpu_addr[ADDR_W-1:BSEL_W];
                  we_q    <= cpu_we;
                  wdata_q <= cpu_wdata;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (serve) begin
                  resp_q  <= 1'b1;
                  state_q <= ST_IDLE;
                  if (!we_q)
                     rdata_q <= hit ? rd_data : vb_word;
               end else if (go_fill) begin
                  vway_q  <= victim_way;
                  fcnt_q  <= '0;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (rf_gnt)
                  state_q <= ST_FILL;
            end
            ST_FILL: begin
               if (rf_valid) begin
                  fcnt_q <= fcnt_q + 1'b1;
                  if (fill_last)
                     state_q <= ST_LOOKUP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready = (state_q == ST_IDLE);
   assign cpu_resp  = resp_q;
   assign cpu_rdata = rdata_q;
   assign rf_req    = (state_q == ST_REQ);
   assign rf_addr   = {req_baddr, {OFFS_W{1'b0}}};
endmodule

// File: rtl/dc_wb2way_chk.sv
module dc_wb2way_chk #(
   parameter int ADDR_W = 44,
   parameter int OFFS_W = 6,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              cpu_resp,
   input logic              rf_req,
   input logic              rf_gnt,
   input logic [ADDR_W-1:0] rf_addr,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [WORD_W-1:0] wb_data
);
   localparam int BSEL_W = $clog2(WORD_W / 8);

   AST_RF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rf_req |-> (rf_addr[OFFS_W-1:0] == '0)); // R6
   AST_RF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_gnt) |=> (rf_req && $stable(rf_addr))); // R6
   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R9
   AST_WB_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_addr[BSEL_W-1:0] == '0)); // R9
   AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready) |=> !cpu_ready); // R13
   AST_NO_REFILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !rf_req); // R13
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp |=> !cpu_resp); // R3
endmodule

bind dc_wb2way dc_wb2way_chk #(
   .ADDR_W (ADDR_W),
   .OFFS_W (OFFS_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .cpu_resp  (cpu_resp),
   .rf_req    (rf_req),
   .rf_gnt    (rf_gnt),
   .rf_addr   (rf_addr),
   .wb_valid  (wb_valid),
   .wb_ready  (wb_ready),
   .wb_addr   (wb_addr),
   .wb_data   (wb_data)
);

// File: tb/dc_wb2way_bench.sv
module dc_wb2way_bench;
   localparam int ADDR_W = 44;
   localparam int IDX_W  = 4;
   localparam int OFFS_W = 6;
   localparam int WORD_W = 32;
   localparam int WORDS  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [WORD_W-1:0] cpu_wdata = '0;
   logic              cpu_ready, cpu_resp;
   logic [WORD_W-1:0] cpu_rdata;
   logic              rf_req;
   logic [ADDR_W-1:0] rf_addr;
   logic              rf_gnt = 1'b0;
   logic              rf_valid = 1'b0;
   logic [WORD_W-1:0] rf_data = '0;
   logic              wb_valid;
   logic [ADDR_W-1:0] wb_addr;
   logic [WORD_W-1:0] wb_data;
   logic              wb_ready = 1'b0;

   dc_wb2way #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .OFFS_W (OFFS_W),
      .WORD_W (WORD_W)
   ) u_dc_wb2way (.*);

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] mem  [logic [43:0]];
   logic [31:0] refm [logic [43:0]];

   int          rf_cnt = 0;
   int          wb_cnt = 0;
   logic [43:0] last_rf_addr = '0;
   logic [43:0] last_wb_addr = '0;
   bit          overlap_seen = 1'b0;
   bit          wb_hold = 1'b0;
   int          fill_left = 0;
   logic [43:0] fill_base = '0;

   logic [31:0] acc_rd;
   int          acc_cyc;
   bit          acc_ready_mid;
   bit          acc_done;

   function automatic logic [31:0] initv(input logic [43:0] a);
      return (a[33:2] * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
   endfunction

   function automatic logic [31:0] memrd(input logic [43:0] a);
      return mem.exists(a) ? mem[a] : initv(a);
   endfunction

   function automatic logic [31:0] refrd(input logic [43:0] a);
      return refm.exists(a) ? refm[a] : initv(a);
   endfunction

   function automatic logic [43:0] mk(input logic [33:0] tag, input logic [3:0] idx,
                                      input logic [3:0] wd);
      return {tag, idx, wd, 2'b00};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: decides at the falling edge, design samples at the rising edge
   initial begin
      forever begin
         @(negedge clk);
         rf_gnt   = 1'b0;
         rf_valid = 1'b0;
         if (fill_left > 0) begin
            rf_valid = 1'b1;
            rf_data  = memrd(fill_base + 44'((WORDS - fill_left) * 4));
            fill_left--;
         end else if (rf_req) begin
            rf_gnt       = 1'b1;
            fill_base    = rf_addr;
            fill_left    = WORDS;
            last_rf_addr = rf_addr;
            rf_cnt++;
         end
         if (rf_req && wb_valid)
            overlap_seen = 1'b1;
         wb_ready = !wb_hold;
         if (wb_valid && !wb_hold) begin
            mem[wb_addr] = wb_data;
            last_wb_addr = wb_addr;
            wb_cnt++;
         end
      end
   end

   task automatic access(input logic we, input logic [43:0] a, input logic [31:0] d);
      acc_done = 1'b0;
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = a;
      cpu_wdata = d;
      if (we) refm[a] = d;
      @(negedge clk);
      cpu_req       = 1'b0;
      acc_cyc       = 1;
      acc_ready_mid = cpu_ready;
      while (!cpu_resp) begin
         @(negedge clk);
         acc_cyc++;
      end
      acc_rd   = cpu_rdata;
      acc_done = 1'b1;
   endtask

   task automatic load_chk(input string req, input logic [43:0] a);
      access(1'b0, a, '0);
      chk(req, acc_rd, refrd(a));
   endtask

   task automatic drain_wait();
      @(negedge clk);
      while (wb_valid) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R2 cpu_ready after reset", cpu_ready, 1);
      chk("R2 cpu_resp after reset", cpu_resp, 0);
      chk("R2 rf_req after reset", rf_req, 0);
      chk("R2 wb_valid after reset", wb_valid, 0);
   endtask

   task automatic t_first_miss();
      int r0 = rf_cnt;
      logic [43:0] a = mk(34'h1, 4'd1, 4'd2);
      load_chk("R4 first load data", a);
      chk("R2 first access misses", rf_cnt - r0, 1);
      chk("R6 refill block base", last_rf_addr, {a[43:6], 6'b0});
      chk("R13 cpu_ready low while busy", acc_ready_mid, 0);
      r0 = rf_cnt;
      load_chk("R1 same-block other word data", mk(34'h1, 4'd1, 4'd5));
      chk("R1 same block shares line, no refill", rf_cnt - r0, 0);
      chk("R3 hit latency two edges", acc_cyc, 2);
   endtask

   task automatic t_store_hit();
      int r0 = rf_cnt;
      int w0 = wb_cnt;
      access(1'b1, mk(34'h1, 4'd1, 4'd3), 32'hCAFE_0003);
      chk("R5 store hit no refill", rf_cnt - r0, 0);
      chk("R5 store hit no memory write", wb_cnt - w0, 0);
      load_chk("R5 store hit readback", mk(34'h1, 4'd1, 4'd3));
   endtask

   task automatic t_alloc_and_lru();
      int r0 = rf_cnt;
      int w0;
      logic [43:0] b = mk(34'h2, 4'd1, 4'd7);
      access(1'b1, b, 32'hB0B0_0007);
      chk("R7 store miss refills", rf_cnt - r0, 1);
      r0 = rf_cnt;
      load_chk("R7 allocated store readback", b);
      load_chk("R8 first block kept in other way", mk(34'h1, 4'd1, 4'd3));
      chk("R8 invalid way filled first", rf_cnt - r0, 0);
      w0 = wb_cnt;
      load_chk("R4 third block load", mk(34'h3, 4'd1, 4'd0));
      drain_wait();
      chk("R9 dirty victim writes whole block", wb_cnt - w0, WORDS);
      chk("R1 write-back at victim tag and index", last_wb_addr, mk(34'h2, 4'd1, 4'd15));
      chk("R7 write-back carries stored word", memrd(b), 32'hB0B0_0007);
      r0 = rf_cnt;
      load_chk("R8 recently used block survives", mk(34'h1, 4'd1, 4'd3));
      chk("R8 LRU way was replaced", rf_cnt - r0, 0);
   endtask

   task automatic t_clean_evict();
      int w0 = wb_cnt;
      load_chk("R4 clean D", mk(34'h1, 4'd2, 4'd0));
      load_chk("R4 clean E", mk(34'h2, 4'd2, 4'd0));
      load_chk("R4 clean F", mk(34'h3, 4'd2, 4'd1));
      drain_wait();
      chk("R9 clean victim no write-back", wb_cnt - w0, 0);
   endtask

   task automatic t_victim_forward();
      int r0;
      logic [43:0] g = mk(34'h1, 4'd3, 4'd4);
      wb_hold = 1'b1;
      access(1'b1, g, 32'h6060_0004);
      access(1'b1, mk(34'h2, 4'd3, 4'd4), 32'h7070_0004);
      overlap_seen = 1'b0;
      load_chk("R4 load during parked write-back", mk(34'h3, 4'd3, 4'd9));
      chk("R10 refill overlaps parked write-back", overlap_seen, 1);
      r0 = rf_cnt;
      load_chk("R12 load served from victim buffer", g);
      chk("R12 buffer hit needs no refill", rf_cnt - r0, 0);
      r0 = rf_cnt;
      fork
         access(1'b1, mk(34'h1, 4'd3, 4'd8), 32'h6060_0008);
         begin
            repeat (30) @(negedge clk);
            chk("R12 store to parked block waits", acc_done, 0);
            chk("R12 no refill while parked", rf_cnt - r0, 0);
            wb_hold = 1'b0;
         end
      join
      load_chk("R12 earlier store kept after drain", g);
      load_chk("R12 new store applied", mk(34'h1, 4'd3, 4'd8));
   endtask

   task automatic t_buffer_full();
      int r0;
      wb_hold = 1'b1;
      access(1'b1, mk(34'h1, 4'd4, 4'd0), 32'hA1);
      access(1'b1, mk(34'h2, 4'd4, 4'd0), 32'hA2);
      load_chk("R4 park first victim", mk(34'h3, 4'd4, 4'd0));
      access(1'b1, mk(34'h1, 4'd5, 4'd1), 32'hB1);
      access(1'b1, mk(34'h2, 4'd5, 4'd1), 32'hB2);
      r0 = rf_cnt;
      fork
         load_chk("R11 stalled load data", mk(34'h3, 4'd5, 4'd1));
         begin
            repeat (30) @(negedge clk);
            chk("R11 no refill while buffer occupied", rf_cnt - r0, 0);
            wb_hold = 1'b0;
         end
      join
      chk("R11 refill after buffer drained", rf_cnt - r0, 1);
      drain_wait();
      load_chk("R4 second victim reloaded", mk(34'h1, 4'd5, 4'd1));
      load_chk("R4 first victim reloaded", mk(34'h1, 4'd4, 4'd0));
   endtask

   task automatic t_sweep();
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (lf[9])
            access(1'b1, mk(34'(1 + lf[1:0]), 4'(8 + lf[4:3]), lf[8:5]), lf);
         else
            load_chk("R4 mixed sweep load", mk(34'(1 + lf[1:0]), 4'(8 + lf[4:3]), lf[8:5]));
      end
      drain_wait();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_miss();
      t_store_hit();
      t_alloc_and_lru();
      t_clean_evict();
      t_victim_forward();
      t_buffer_full();
      t_sweep();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule